// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits between several requester ports and a small shared word memory. It makes load-exclusive and store-exclusive operations atomic across those ports. Each port can issue a plain load, a plain store, a load-exclusive or a store-exclusive. A request carries a word base, a word offset, a shared flag and write data.

Every port has its own local monitor, which records whether an exclusive read is open and for which address. A global monitor keeps one tagged address per port, and only for exclusive reads that carry the shared flag. A store-exclusive writes memory only when both checks succeed. It returns a status bit: 0 means memory was written, 1 means the write was refused. Because the check is conditional, several requesters can race to claim a lock word that reads as zero, and only one of them gets it.

Requests that arrive in the same cycle are taken one at a time by a fixed-priority arbiter. The lowest port index wins, and one memory operation runs per cycle.

Top module: `excl_mon_top`

## Requirements
- R1: The operation code is 2 bits per port: 0 = plain load, 1 = plain store, 2 = load-exclusive, 3 = store-exclusive. A granted load or load-exclusive returns the addressed word on `rsp_rdata` in the cycle after the grant. In that same cycle, bit `rsp_valid[p]` of the granted port is high for exactly one cycle.
- R2: The word address is (`base` + `ofs`) modulo 2^ADDR_W. `ofs` is an 8-bit word count, 0 to 255, which corresponds to a byte offset of 0 to 1020 in steps of 4.
- R3: A granted plain store writes its data and responds with status 0.
- R4: A store-exclusive passes only if two conditions hold. First, the port's local monitor must be active for the same address. Second, when the shared flag is set, the port's global tag must also hold that address. A pass writes memory and returns status 0. A fail leaves memory unchanged and returns status 1. A store-exclusive with no earlier load-exclusive also fails.
- R5: Every store-exclusive, whether it passes or fails, returns the issuing port's local monitor to the open state.
- R6: A store that writes memory, plain or exclusive, removes the global tag of every other port tagged at that address. It leaves the writer's own tag alone.
- R7: A shared load-exclusive tags its address for the issuing port. When all ports read a zero lock word and then race with store-exclusives, exactly one of them succeeds.
- R8: A non-shared exclusive pair is checked against the local monitor only.
- R9: Among ports with `req_valid` high, `req_grant` is high for the lowest index only, in the same cycle. A port that is not granted must hold its request.
- R10: After reset, all monitors are open, no address is tagged, every memory word reads 0 and no response is pending.
- R11: `rsp_status` is high only in a response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_op | input | 2*N_PORTS | Operation code per port |
| req_shared | input | N_PORTS | Shared flag per port |
| req_base | input | N_PORTS*ADDR_W | Word base address per port |
| req_ofs | input | N_PORTS*OFS_W | Word offset per port |
| req_wdata | input | N_PORTS*DATA_W | Store data per port |
| req_grant | output | N_PORTS | Request accepted this cycle |
| rsp_valid | output | N_PORTS | Response for the port, one cycle after grant |
| rsp_rdata | output | DATA_W | Read data of the responding load |
| rsp_status | output | 1 | Store-exclusive failure flag |

## Verification
Some properties are checked on every cycle by the assertions. These are: the grant is one-hot and goes to the lowest requesting port; every response follows a grant; status appears only with a response; a store-exclusive always leaves its local monitor open; and a write drops any matching tag held by other ports.

Other behaviour can only be shown by the bench's scenarios, because it depends on the contents of memory or on a sequence of operations. This covers: which store-exclusives pass or fail after stale, foreign or missing reservations; that a refused write leaves memory untouched; the address wrap; the three-way lock race; and the state left after reset.

// File: rtl/excl_mon_pkg.sv
`timescale 1ns/1ps
package excl_mon_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LDX   = 2'd2,
        OP_STX   = 2'd3
    } op_e;
endpackage

// File: rtl/excl_mon_arb.sv
`timescale 1ns/1ps
module excl_mon_arb #(
    parameter int N_PORTS = 3,
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    output logic [N_PORTS-1:0] gnt,
    output logic               any,
    output logic [PW-1:0]      idx
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = '0;
                gnt[i] = 1'b1;
                any = 1'b1;
                idx = PW'(i);
            end
        end
    end

    assert_grant_onehot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_prio
        assert_grant_requested_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            gnt[gi] |-> req[gi]);
        if (gi > 0) begin : g_low
            assert_lowest_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
                gnt[gi] |-> (req[gi-1:0] == '0));
        end
    end
endmodule

// File: rtl/excl_mon_mem.sv
`timescale 1ns/1ps
module excl_mon_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
        logic [DATA_W-1:0]            rd;
    } mem_t;

    mem_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (rd_en) m_d.rd = m_q.word[addr];
        if (wr_en) m_d.word[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign rdata = m_q.rd;
endmodule

// File: rtl/excl_mon_track.sv
`timescale 1ns/1ps
module excl_mon_track
    import excl_mon_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADDR_W  = 6,
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [PW-1:0]     op_port,
    input  op_e               op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_shared,
    output logic              stx_pass,
    output logic              wr_en
);
    typedef struct packed {
        logic [N_PORTS-1:0]             loc_busy;
        logic [N_PORTS-1:0][ADDR_W-1:0] loc_addr;
        logic [N_PORTS-1:0]             tag_ok;
        logic [N_PORTS-1:0][ADDR_W-1:0] tag_addr;
    } mon_t;

    mon_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        stx_pass = 1'b0;
        wr_en    = 1'b0;
        if (op_valid) begin
            case (op_kind)
                OP_LDX: begin
                    s_d.loc_busy[op_port] = 1'b1;
                    s_d.loc_addr[op_port] = op_addr;
                    if (op_shared) begin
                        s_d.tag_ok[op_port]   = 1'b1;
                        s_d.tag_addr[op_port] = op_addr;
                    end
                end
                OP_STX: begin
                    stx_pass = s_q.loc_busy[op_port]
                            && (s_q.loc_addr[op_port] == op_addr)
                            && (!op_shared
                                || (s_q.tag_ok[op_port] && (s_q.tag_addr[op_port] == op_addr)));
                    s_d.loc_busy[op_port] = 1'b0;
                end
                default: ;
            endcase
            wr_en = (op_kind == OP_STORE) || stx_pass;
            if (wr_en) begin
                for (int q = 0; q < N_PORTS; q++) begin
                    if ((PW'(q) != op_port) && s_q.tag_ok[q] && (s_q.tag_addr[q] == op_addr))
                        s_d.tag_ok[q] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar gq = 0; gq < N_PORTS; gq++) begin : g_chk
        assert_stx_opens_local_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_kind == OP_STX && op_port == PW'(gq)) |=> !s_q.loc_busy[gq]);
        assert_write_drops_tag_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && op_port != PW'(gq) && s_q.tag_ok[gq] && s_q.tag_addr[gq] == op_addr)
            |=> !s_q.tag_ok[gq]);
    end
endmodule

// File: rtl/excl_mon_top.sv
`timescale 1ns/1ps
module excl_mon_top
    import excl_mon_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADDR_W  = 6,
    parameter int OFS_W   = 8,
    parameter int DATA_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_valid,
    input  logic [2*N_PORTS-1:0]        req_op,
    input  logic [N_PORTS-1:0]          req_shared,
    input  logic [N_PORTS*ADDR_W-1:0]   req_base,
    input  logic [N_PORTS*OFS_W-1:0]    req_ofs,
    input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
    output logic [N_PORTS-1:0]          req_grant,
    output logic [N_PORTS-1:0]          rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic                        rsp_status
);
    localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    typedef struct packed {
        logic [N_PORTS-1:0] valid;
        logic               status;
    } rsp_t;

    logic              g_any;
    logic [PW-1:0]     g_idx;
    op_e               sel_op;
    logic              sel_sh;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              pass, wr_en;
    rsp_t              r_d, r_q;

    excl_mon_arb #(.N_PORTS(N_PORTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid),
        .gnt(req_grant), .any(g_any), .idx(g_idx)
    );

    always_comb begin
        sel_op    = OP_LOAD;
        sel_sh    = 1'b0;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (g_idx == PW'(i)) begin
                sel_op    = op_e'(req_op[2*i +: 2]);
                sel_sh    = req_shared[i];
                sel_addr  = req_base[ADDR_W*i +: ADDR_W] + ADDR_W'(req_ofs[OFS_W*i +: OFS_W]);
                sel_wdata = req_wdata[DATA_W*i +: DATA_W];
            end
        end
    end

    excl_mon_track #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .op_valid(g_any), .op_port(g_idx),
        .op_kind(sel_op), .op_addr(sel_addr), .op_shared(sel_sh),
        .stx_pass(pass), .wr_en(wr_en)
    );

    excl_mon_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_en(g_any && (sel_op == OP_LOAD || sel_op == OP_LDX)),
        .wr_en(wr_en), .addr(sel_addr), .wdata(sel_wdata), .rdata(rsp_rdata)
    );

    always_comb begin
        r_d.valid  = g_any ? req_grant : '0;
        r_d.status = g_any && (sel_op == OP_STX) && !pass;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid  = r_q.valid;
    assign rsp_status = r_q.status;

    for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_rsp
        assert_rsp_after_grant_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[gp] |-> $past(req_grant[gp]));
    end

    assert_status_in_rsp_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status |-> (rsp_valid != '0));
endmodule

// File: tb/sim_excl_mon_top.sv
`timescale 1ns/1ps
module sim_excl_mon_top;
    localparam int N = 3, AW = 6, OW = 8, DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_op = '0;
    logic [N-1:0]    req_shared = '0;
    logic [N*AW-1:0] req_base = '0;
    logic [N*OW-1:0] req_ofs = '0;
    logic [N*DW-1:0] req_wdata = '0;
    logic [N-1:0]    req_grant, rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic            rsp_status;

    int nvec = 0, nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    excl_mon_top #(.N_PORTS(N), .ADDR_W(AW), .OFS_W(OW), .DATA_W(DW)) u0 (.*);

    typedef struct packed {
        logic [1:0]  port;
        logic [1:0]  op;
        logic        sh;
        logic [5:0]  base;
        logic [7:0]  ofs;
        logic [31:0] wd;
        logic [31:0] er;
        logic        es;
    } vec_t;

    localparam int NV = 22;
    // op: 0 load, 1 store, 2 load-excl, 3 store-excl
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 1'b0, 6'd4,  8'd0,   32'h000000A5, 32'h0,          1'b0}, // R3
        '{2'd0, 2'd0, 1'b0, 6'd0,  8'd4,   32'h0,        32'h000000A5,   1'b0}, // R2
        '{2'd1, 2'd3, 1'b1, 6'd8,  8'd0,   32'h7,        32'h0,          1'b1}, // R4 no reservation
        '{2'd1, 2'd0, 1'b0, 6'd8,  8'd0,   32'h0,        32'h0,          1'b0}, // R4 memory kept
        '{2'd1, 2'd2, 1'b1, 6'd8,  8'd0,   32'h0,        32'h0,          1'b0}, // R7
        '{2'd1, 2'd3, 1'b1, 6'd9,  8'd0,   32'h3,        32'h0,          1'b1}, // R4 wrong address
        '{2'd1, 2'd3, 1'b1, 6'd8,  8'd0,   32'h3,        32'h0,          1'b1}, // R5 monitor opened
        '{2'd1, 2'd2, 1'b1, 6'd8,  8'd0,   32'h0,        32'h0,          1'b0},
        '{2'd1, 2'd3, 1'b1, 6'd8,  8'd0,   32'h3,        32'h0,          1'b0}, // R4 pass
        '{2'd1, 2'd0, 1'b0, 6'd8,  8'd0,   32'h0,        32'h3,          1'b0},
        '{2'd2, 2'd2, 1'b1, 6'd8,  8'd0,   32'h0,        32'h3,          1'b0},
        '{2'd0, 2'd2, 1'b1, 6'd8,  8'd0,   32'h0,        32'h3,          1'b0},
        '{2'd0, 2'd1, 1'b0, 6'd8,  8'd0,   32'h11,       32'h0,          1'b0}, // R6 plain store
        '{2'd2, 2'd3, 1'b1, 6'd8,  8'd0,   32'h22,       32'h0,          1'b1}, // R6 tag lost
        '{2'd0, 2'd3, 1'b1, 6'd8,  8'd0,   32'h33,       32'h0,          1'b0}, // R6 own tag kept
        '{2'd0, 2'd0, 1'b0, 6'd8,  8'd0,   32'h0,        32'h33,         1'b0},
        '{2'd2, 2'd2, 1'b0, 6'd20, 8'd0,   32'h0,        32'h0,          1'b0}, // R8
        '{2'd1, 2'd1, 1'b0, 6'd20, 8'd0,   32'h5,        32'h0,          1'b0},
        '{2'd2, 2'd3, 1'b0, 6'd20, 8'd0,   32'h6,        32'h0,          1'b0}, // R8 local only
        '{2'd2, 2'd0, 1'b0, 6'd20, 8'd0,   32'h0,        32'h6,          1'b0},
        '{2'd0, 2'd1, 1'b0, 6'd60, 8'd4,   32'h77,       32'h0,          1'b0}, // R2 wrap
        '{2'd1, 2'd0, 1'b0, 6'd1,  8'd255, 32'h0,        32'h77,         1'b0}  // R2 max offset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_port(input int p, input logic [1:0] op, input logic sh,
                            input logic [5:0] base, input logic [7:0] ofs, input logic [31:0] wd);
        req_valid[p]          = 1'b1;
        req_op[2*p +: 2]      = op;
        req_shared[p]         = sh;
        req_base[AW*p +: AW]  = base;
        req_ofs[OW*p +: OW]   = ofs;
        req_wdata[DW*p +: DW] = wd;
    endtask

    task automatic issue(input int p, input logic [1:0] op, input logic sh, input logic [5:0] base,
                         input logic [7:0] ofs, input logic [31:0] wd,
                         output logic [N-1:0] rv, output logic [31:0] rd, output logic st);
        @(negedge clk);
        set_port(p, op, sh, base, ofs, wd);
        @(negedge clk);
        rv = rsp_valid; rd = rsp_rdata; st = rsp_status;
        req_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rv;
        logic [31:0]  rd;
        logic         st;
        logic [N-1:0] seen, stat;
        int           wins;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 no response after reset", 32'(rsp_valid), 32'h0);
        check("R10 status low after reset", 32'(rsp_status), 32'h0);

        for (int k = 0; k < NV; k++) begin
            issue(int'(VECS[k].port), VECS[k].op, VECS[k].sh, VECS[k].base, VECS[k].ofs,
                  VECS[k].wd, rv, rd, st);
            check($sformatf("R1 vector %0d valid", k), 32'(rv), 32'(1) << VECS[k].port);
            check($sformatf("R3 R4 vector %0d status", k), 32'(st), 32'(VECS[k].es));
            if (!VECS[k].op[0])
                check($sformatf("R1 R2 vector %0d rdata", k), rd, VECS[k].er);
        end

        // R7: all three ports reserve lock word 40, then race
        for (int p = 0; p < N; p++) begin
            issue(p, 2'd2, 1'b1, 6'd40, 8'd0, 32'h0, rv, rd, st);
            check("R7 lock reads zero", rd, 32'h0);
        end
        @(negedge clk);
        for (int p = 0; p < N; p++) set_port(p, 2'd3, 1'b1, 6'd40, 8'd0, 32'(p + 1));
        #1;
        check("R9 lowest port granted", 32'(req_grant), 32'h1);
        seen = '0; stat = '0;
        for (int c = 0; c < 2 * N; c++) begin
            @(negedge clk);
            for (int p = 0; p < N; p++) begin
                if (rsp_valid[p]) begin
                    seen[p] = 1'b1; stat[p] = rsp_status; req_valid[p] = 1'b0;
                end
            end
            if (c == 0) begin
                #1;
                check("R9 next port granted after hold", 32'(req_grant), 32'h2);
            end
        end
        wins = 0;
        for (int p = 0; p < N; p++) if (!stat[p]) wins++;
        check("R7 all racers answered", 32'(seen), 32'h7);
        check("R7 exactly one winner", 32'(wins), 32'h1);
        check("R7 port 0 wins", 32'(stat[0]), 32'h0);
        issue(2, 2'd0, 1'b0, 6'd40, 8'd0, 32'h0, rv, rd, st);
        check("R7 lock holds winner data", rd, 32'h1);

        // R10: reset clears reservations and memory
        issue(0, 2'd2, 1'b1, 6'd30, 8'd0, 32'h0, rv, rd, st);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        issue(0, 2'd3, 1'b1, 6'd30, 8'd0, 32'h9, rv, rd, st);
        check("R10 reservation cleared by reset", 32'(st), 32'h1);
        issue(0, 2'd0, 1'b0, 6'd4, 8'd0, 32'h0, rv, rd, st);
        check("R10 memory zero after reset", rd, 32'h0);
        check("R11 no status on load", 32'(st), 32'h0);
        @(negedge clk);
        check("R11 status idle between responses", 32'(rsp_status), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule